// File: doc/BRIEF.md
# EPROM Pulse-and-Verify Programming Sequencer

This block writes an image into a byte-wide UV-erasable PROM of up to 64K locations. A single start command with an inclusive first and last address launches the job. The block raises the programming supply, then applies the program voltage, and then walks the range one address at a time in ascending order. For each address it asks an upstream source for the target byte and reads back what the cell already holds. It then applies fixed-width program pulses, reading the byte again after each one, until the readback equals the target. An erased cell reads as ones, and a pulse can only clear bits.

After the last address the block removes the program voltage and drops the supply to nominal. It then fetches every target byte again and compares it with a plain read of the array. The job ends with done raised and a fail code that gives the cause. When the job fails, the code comes with the address that failed. The block does not generate the analog voltages. It only drives the enables for them.

Top module: `eprom_prog_seq`

## Requirements
- R1: While reset is high and after its release, with no job started: rom_ce_n=1, rom_oe_n=1, rom_dout_en=0, vpp_en=0, vcc_hi=0, busy=0, done=0, fail=0, req_valid=0.
- R2: vcc_hi goes high first, and vpp_en rises no sooner than SETTLE_CYC cycles after it. On shutdown vpp_en falls first, and vcc_hi falls no sooner than SETTLE_CYC cycles after that. vpp_en is never high while vcc_hi is low.
- R3: A program pulse holds rom_ce_n=0, rom_oe_n=1 and rom_dout_en=1 with rom_dout = target, while vpp_en=1 and vcc_hi=1. It lasts exactly SETTLE-independent PULSE_CYC = (CLK_HZ/1000)*PULSE_US/1000 cycles.
- R4: The cycle after every pulse starts a verify read: rom_ce_n=0, rom_oe_n=0, rom_dout_en=0, with vpp_en=1 and vcc_hi=1. Every read lasts READ_CYC cycles and samples rom_din in its last cycle.
- R5: Pulses repeat at an address until its readback equals the target. A byte that already matches receives no pulse.
- R6: A byte still wrong after MAX_PULSES pulses ends the job with fail_code=2 and fail_addr set to that address. No further address is touched, and the power steps down as in R2.
- R7: If a readback has a 0 where the target has a 1, the job ends with fail_code=1 at that address. No further pulse is applied.
- R8: Addresses go from first_addr to last_addr in ascending order, with one target request per address in each pass. req_valid stays high with req_addr equal to the address until rsp_valid, and rsp_data is taken in that cycle.
- R9: After a clean programming pass the block fetches every address again. It reads each one with vcc_hi=0 and vpp_en=0 and compares it with the target. The first mismatch ends the job with fail_code=3 at that address.
- R10: At the end of a job done=1 and busy=0, and both hold until the next start. fail=1 exactly when fail_code is nonzero, and 0 means success. A start clears done.
- R11: A start pulse while busy has no effect on the job in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a job (taken only when idle) |
| first_addr | input | ADDR_W | First address of the range |
| last_addr | input | ADDR_W | Last address of the range (inclusive) |
| busy | output | 1 | Job in progress |
| done | output | 1 | Job finished |
| fail | output | 1 | Job finished with an error |
| fail_code | output | 2 | 0 ok, 1 unprogrammable, 2 pulse limit, 3 final verify |
| fail_addr | output | ADDR_W | Address that caused the failure |
| req_valid | output | 1 | Target byte request |
| req_addr | output | ADDR_W | Address whose target byte is requested |
| rsp_valid | input | 1 | Target byte present |
| rsp_data | input | DATA_W | Target byte |
| rom_addr | output | ADDR_W | Memory address bus |
| rom_dout | output | DATA_W | Data to program |
| rom_dout_en | output | 1 | Drive rom_dout onto the data pins |
| rom_din | input | DATA_W | Data read from the memory |
| rom_ce_n | output | 1 | Chip enable, active low; low with data driven is the pulse |
| rom_oe_n | output | 1 | Output enable, active low |
| vpp_en | output | 1 | Apply program voltage |
| vcc_hi | output | 1 | Select raised supply |

## Verification
On every cycle the assertions check the power ordering between vpp_en and vcc_hi and that a driven data bus only appears inside a powered pulse. They also check that a pulse is always followed by a read, that the pulse counter stays within its limit, that an unprogrammable byte is never pulsed, and that a pending request holds steady. The per-address pulse counts, the programming result and the exact pulse and settle lengths in cycles can only be shown by the bench's scenarios. The same holds for the request order in both passes, the final pass at nominal supply and each failure cause with its address. For these the bench uses an array model whose cells need a set number of pulses, and a model that tracks those pulses per address on every clock.

// File: rtl/eprom_prog_pkg.sv
package eprom_prog_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SUP_ON,
        ST_VPP_ON,
        ST_FETCH,
        ST_READ,
        ST_EVAL,
        ST_PULSE,
        ST_VPP_OFF,
        ST_SUP_OFF,
        ST_FV_FETCH,
        ST_FV_READ,
        ST_FV_EVAL
    } seq_state_e;

    typedef enum logic [1:0] {
        FC_NONE   = 2'd0,
        FC_UNPROG = 2'd1,
        FC_RETRY  = 2'd2,
        FC_VERIFY = 2'd3
    } fail_code_e;

    typedef struct packed {
        logic vcc_hi;
        logic vpp_en;
        logic ce_n;
        logic oe_n;
        logic dout_en;
        logic req;
    } pin_ctl_t;

    function automatic int us_to_cycles(input int hz, input int us);
        int c;
        c = ((hz / 1000) * us) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic pin_ctl_t pins_for(input seq_state_e s);
        pin_ctl_t p;
        p = '{vcc_hi: 1'b0, vpp_en: 1'b0, ce_n: 1'b1, oe_n: 1'b1,
              dout_en: 1'b0, req: 1'b0};
        case (s)
            ST_SUP_ON:   p.vcc_hi = 1'b1;
            ST_VPP_ON:   begin p.vcc_hi = 1'b1; p.vpp_en = 1'b1; end
            ST_FETCH:    begin p.vcc_hi = 1'b1; p.vpp_en = 1'b1; p.req = 1'b1; end
            ST_READ:     begin p.vcc_hi = 1'b1; p.vpp_en = 1'b1;
                               p.ce_n = 1'b0; p.oe_n = 1'b0; end
            ST_EVAL:     begin p.vcc_hi = 1'b1; p.vpp_en = 1'b1; end
            ST_PULSE:    begin p.vcc_hi = 1'b1; p.vpp_en = 1'b1;
                               p.ce_n = 1'b0; p.dout_en = 1'b1; end
            ST_VPP_OFF:  p.vcc_hi = 1'b1;
            ST_FV_FETCH: p.req = 1'b1;
            ST_FV_READ:  begin p.ce_n = 1'b0; p.oe_n = 1'b0; end
            default:     ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/eprom_prog_timer.sv
module eprom_prog_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/eprom_prog_cmp.sv
module eprom_prog_cmp #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] target,
    input  logic [DW-1:0] readback,
    output logic          match,
    output logic          need_set
);
    assign match    = (target == readback);
    assign need_set = |(target & ~readback);
endmodule

// File: rtl/eprom_prog_addr.sv
module eprom_prog_addr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] first_in,
    input  logic [AW-1:0] last_in,
    input  logic          rewind,
    input  logic          inc,
    output logic [AW-1:0] addr,
    output logic          at_last
);
    logic [AW-1:0] first_q, last_q, addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q <= '0;
            last_q  <= '0;
            addr_q  <= '0;
        end else if (start) begin
            first_q <= first_in;
            last_q  <= last_in;
            addr_q  <= first_in;
        end else if (rewind) begin
            addr_q  <= first_q;
        end else if (inc) begin
            addr_q  <= addr_q + AW'(1);
        end
    end

    assign addr    = addr_q;
    assign at_last = (addr_q == last_q);

    AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        inc |-> (addr_q != last_q)); // R8

endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
    import eprom_prog_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int CLK_HZ     = 50_000_000,
    parameter int PULSE_US   = 100,
    parameter int SETTLE_US  = 10,
    parameter int READ_CYC   = 4,
    parameter int MAX_PULSES = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] first_addr,
    input  logic [ADDR_W-1:0] last_addr,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [1:0]        fail_code,
    output logic [ADDR_W-1:0] fail_addr,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data,
    output logic [ADDR_W-1:0] rom_addr,
    output logic [DATA_W-1:0] rom_dout,
    output logic              rom_dout_en,
    input  logic [DATA_W-1:0] rom_din,
    output logic              rom_ce_n,
    output logic              rom_oe_n,
    output logic              vpp_en,
    output logic              vcc_hi
);
    localparam int PULSE_CYC  = us_to_cycles(CLK_HZ, PULSE_US);
    localparam int SETTLE_CYC = us_to_cycles(CLK_HZ, SETTLE_US);
    localparam int TMR_MAX    = max3(PULSE_CYC, SETTLE_CYC, READ_CYC);
    localparam int TMR_W      = $clog2(TMR_MAX + 1);
    localparam int CNT_W      = $clog2(MAX_PULSES + 1);
    localparam logic [TMR_W-1:0] PULSE_V  = TMR_W'(PULSE_CYC - 1);
    localparam logic [TMR_W-1:0] SETTLE_V = TMR_W'(SETTLE_CYC - 1);
    localparam logic [TMR_W-1:0] READ_V   = TMR_W'(READ_CYC - 1);
    localparam logic [CNT_W-1:0] PMAX     = CNT_W'(MAX_PULSES);

    seq_state_e        state_q, state_d;
    fail_code_e        code_q;
    logic [DATA_W-1:0] target_q, rd_q;
    logic [CNT_W-1:0]  pcnt_q;
    logic [ADDR_W-1:0] faddr_q, addr;
    logic              done_q;
    logic              tmr_load, tmr_zero;
    logic [TMR_W-1:0]  tmr_val;
    logic              a_start, a_rewind, a_inc, at_last;
    logic              match, need_set, give_up;
    pin_ctl_t          pins;

    eprom_prog_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    eprom_prog_addr #(.AW(ADDR_W)) u_addr (
        .clk(clk), .rst(rst), .start(a_start), .first_in(first_addr),
        .last_in(last_addr), .rewind(a_rewind), .inc(a_inc),
        .addr(addr), .at_last(at_last)
    );

    eprom_prog_cmp #(.DW(DATA_W)) u_cmp (
        .target(target_q), .readback(rd_q), .match(match), .need_set(need_set)
    );

    assign give_up = !match && (pcnt_q == PMAX);

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        a_start  = 1'b0;
        a_rewind = 1'b0;
        a_inc    = 1'b0;
        case (state_q)
            ST_IDLE: if (start) begin
                state_d = ST_SUP_ON; tmr_load = 1'b1; tmr_val = SETTLE_V; a_start = 1'b1;
            end
            ST_SUP_ON: if (tmr_zero) begin
                state_d = ST_VPP_ON; tmr_load = 1'b1; tmr_val = SETTLE_V;
            end
            ST_VPP_ON: if (tmr_zero) state_d = ST_FETCH;
            ST_FETCH: if (rsp_valid) begin
                state_d = ST_READ; tmr_load = 1'b1; tmr_val = READ_V;
            end
            ST_READ: if (tmr_zero) state_d = ST_EVAL;
            ST_EVAL: begin
                if (need_set || give_up || (match && at_last)) begin
                    state_d = ST_VPP_OFF; tmr_load = 1'b1; tmr_val = SETTLE_V;
                end else if (match) begin
                    state_d = ST_FETCH; a_inc = 1'b1;
                end else begin
                    state_d = ST_PULSE; tmr_load = 1'b1; tmr_val = PULSE_V;
                end
            end
            ST_PULSE: if (tmr_zero) begin
                state_d = ST_READ; tmr_load = 1'b1; tmr_val = READ_V;
            end
            ST_VPP_OFF: if (tmr_zero) begin
                state_d = ST_SUP_OFF; tmr_load = 1'b1; tmr_val = SETTLE_V;
            end
            ST_SUP_OFF: if (tmr_zero) begin
                if (code_q != FC_NONE) state_d = ST_IDLE;
                else begin state_d = ST_FV_FETCH; a_rewind = 1'b1; end
            end
            ST_FV_FETCH: if (rsp_valid) begin
                state_d = ST_FV_READ; tmr_load = 1'b1; tmr_val = READ_V;
            end
            ST_FV_READ: if (tmr_zero) state_d = ST_FV_EVAL;
            ST_FV_EVAL: begin
                if (!match || at_last) state_d = ST_IDLE;
                else begin state_d = ST_FV_FETCH; a_inc = 1'b1; end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            code_q   <= FC_NONE;
            target_q <= '0;
            rd_q     <= '0;
            pcnt_q   <= '0;
            faddr_q  <= '0;
            done_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            case (state_q)
                ST_IDLE: if (start) begin
                    code_q  <= FC_NONE;
                    faddr_q <= '0;
                    done_q  <= 1'b0;
                end
                ST_FETCH: if (rsp_valid) begin
                    target_q <= rsp_data;
                    pcnt_q   <= '0;
                end
                ST_FV_FETCH: if (rsp_valid) target_q <= rsp_data;
                ST_READ, ST_FV_READ: if (tmr_zero) rd_q <= rom_din;
                ST_EVAL: begin
                    if (need_set) begin
                        code_q <= FC_UNPROG; faddr_q <= addr;
                    end else if (give_up) begin
                        code_q <= FC_RETRY; faddr_q <= addr;
                    end else if (!match) begin
                        pcnt_q <= pcnt_q + CNT_W'(1);
                    end
                end
                ST_SUP_OFF: if (tmr_zero && code_q != FC_NONE) done_q <= 1'b1;
                ST_FV_EVAL: begin
                    if (!match) begin
                        code_q <= FC_VERIFY; faddr_q <= addr; done_q <= 1'b1;
                    end else if (at_last) begin
                        done_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign pins        = pins_for(state_q);
    assign vcc_hi      = pins.vcc_hi;
    assign vpp_en      = pins.vpp_en;
    assign rom_ce_n    = pins.ce_n;
    assign rom_oe_n    = pins.oe_n;
    assign rom_dout_en = pins.dout_en;
    assign req_valid   = pins.req;
    assign req_addr    = addr;
    assign rom_addr    = addr;
    assign rom_dout    = target_q;
    assign busy        = (state_q != ST_IDLE);
    assign done        = done_q;
    assign fail        = done_q && (code_q != FC_NONE);
    assign fail_code   = code_q;
    assign fail_addr   = faddr_q;

    AST_VPP_WITH_SUPPLY: assert property (@(posedge clk) disable iff (rst)
        vpp_en |-> vcc_hi); // R2
    AST_SUPPLY_DROP_LAST: assert property (@(posedge clk) disable iff (rst)
        $fell(vcc_hi) |-> $past(!vpp_en)); // R2
    AST_PULSE_POWERED: assert property (@(posedge clk) disable iff (rst)
        rom_dout_en |-> (!rom_ce_n && rom_oe_n && vpp_en && vcc_hi)); // R3
    AST_PULSE_THEN_VERIFY: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PULSE && tmr_zero) |=> (!rom_ce_n && !rom_oe_n && !rom_dout_en)); // R4
    AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (rst)
        pcnt_q <= PMAX); // R6
    AST_NO_PULSE_UNPROG: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EVAL && need_set) |=> !rom_dout_en); // R7
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !rsp_valid) |=> (req_valid && $stable(req_addr))); // R8
    AST_DONE_SAFE: assert property (@(posedge clk) disable iff (rst)
        done |-> (!vpp_en && !vcc_hi && rom_ce_n && !busy)); // R10

endmodule

// File: tb/test_eprom_prog_seq.sv
module test_eprom_prog_seq;
    localparam int CLK_HZ = 1_000_000;
    localparam int PUS    = 20;
    localparam int SUS    = 5;
    localparam int RCYC   = 2;
    localparam int MAXP   = 4;
    localparam int PULSE  = 20;
    localparam int SETTLE = 5;
    localparam int WD     = 150000;

    logic        clk = 0, rst = 1, start = 0;
    logic [15:0] first_addr = 0, last_addr = 0;
    logic        busy, done, fail, req_valid, rsp_valid = 0;
    logic [1:0]  fail_code;
    logic [15:0] fail_addr, req_addr, rom_addr;
    logic [7:0]  rsp_data = 0, rom_dout, rom_din;
    logic        rom_dout_en, rom_ce_n, rom_oe_n, vpp_en, vcc_hi;

    int checks = 0, errors = 0, cyc = 0;
    logic [7:0] mem [0:255];
    logic [7:0] mem0 [0:255];
    logic [7:0] img [0:255];
    int need [0:255];
    int pcnt [0:255];
    logic [15:0] hs_q [$];
    int pulse_len = 0, vcc_run = 0, vpp_low_run = 0, rsp_wait = 0, fv_reads = 0;
    bit pulse_bad = 0, ord_bad = 0, fv_bad = 0, prev_vpp = 0, prev_vcc = 0;
    bit decay_on = 0;
    logic [7:0] pulse_a = 0, pulse_d = 0, decay_a = 0;

    always #10 clk = ~clk;

    eprom_prog_seq #(.CLK_HZ(CLK_HZ), .PULSE_US(PUS), .SETTLE_US(SUS),
                     .READ_CYC(RCYC), .MAX_PULSES(MAXP)) i_eprom_prog_seq (
        .clk(clk), .rst(rst), .start(start), .first_addr(first_addr),
        .last_addr(last_addr), .busy(busy), .done(done), .fail(fail),
        .fail_code(fail_code), .fail_addr(fail_addr), .req_valid(req_valid),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rom_addr(rom_addr), .rom_dout(rom_dout), .rom_dout_en(rom_dout_en),
        .rom_din(rom_din), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n),
        .vpp_en(vpp_en), .vcc_hi(vcc_hi));

    assign rom_din = (!rom_ce_n && !rom_oe_n && !rom_dout_en) ? mem[rom_addr[7:0]] : 8'h00;

    task automatic check(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // per-clock reference model of the array and the pin protocol
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (!rom_ce_n && rom_dout_en) begin
                if (!(vpp_en && vcc_hi && rom_oe_n)) pulse_bad = 1;
                pulse_len++;
                pulse_a = rom_addr[7:0];
                pulse_d = rom_dout;
            end else if (pulse_len > 0) begin
                check(pulse_len == PULSE && !pulse_bad, "R3 pulse width/conditions", pulse_len, PULSE);
                check(!rom_ce_n && !rom_oe_n && !rom_dout_en && vpp_en && vcc_hi,
                      "R4 verify read follows pulse", {rom_ce_n, rom_oe_n, rom_dout_en}, 0);
                pcnt[pulse_a]++;
                if (pcnt[pulse_a] >= need[pulse_a]) mem[pulse_a] = mem[pulse_a] & pulse_d;
                pulse_len = 0;
                pulse_bad = 0;
            end
            if (vpp_en && !prev_vpp)
                check(vcc_run >= SETTLE, "R2 supply settles before vpp", vcc_run, SETTLE);
            if (!vcc_hi && prev_vcc)
                check(vpp_low_run >= SETTLE, "R2 vpp released before supply", vpp_low_run, SETTLE);
            if (vpp_en && !vcc_hi) ord_bad = 1;
            if (!vpp_en && prev_vpp && decay_on) mem[decay_a] = mem[decay_a] | 8'h01;
            if (!rom_ce_n && !rom_oe_n && !vcc_hi) begin
                fv_reads++;
                if (vpp_en) fv_bad = 1;
            end
            vcc_run     = vcc_hi ? vcc_run + 1 : 0;
            vpp_low_run = vpp_en ? 0 : vpp_low_run + 1;
            prev_vpp    = vpp_en;
            prev_vcc    = vcc_hi;
        end
    end

    // target byte source, latency of a few cycles
    always @(negedge clk) begin
        if (rsp_valid) rsp_valid = 0;
        else if (req_valid) begin
            if (rsp_wait == 2) begin
                rsp_valid = 1;
                rsp_data  = img[req_addr[7:0]];
                hs_q.push_back(req_addr);
                rsp_wait  = 0;
            end else rsp_wait++;
        end
    end

    initial begin
        wait (cyc > WD);
        errors++;
        $display("FAIL watchdog: run did not finish, actual %0d expected <%0d cycles", cyc, WD);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic blank();
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'hFF; img[i] = 8'hFF; need[i] = 1;
        end
    endtask

    task automatic run_job(input logic [15:0] f, input logic [15:0] l, input bit poke);
        for (int i = 0; i < 256; i++) begin pcnt[i] = 0; mem0[i] = mem[i]; end
        hs_q.delete();
        ord_bad = 0; fv_reads = 0; fv_bad = 0;
        @(negedge clk); first_addr = f; last_addr = l; start = 1;
        @(negedge clk); start = 0;
        check(busy && !done && vcc_hi && !vpp_en, "R10 start clears done, R2 supply first",
              {busy, done, vcc_hi, vpp_en}, 4'b1010);
        if (poke) begin
            repeat (30) @(negedge clk);
            first_addr = 16'h0080; last_addr = 16'h0081; start = 1;
            @(negedge clk); start = 0;
        end
        while (!done && cyc < WD) @(negedge clk);
    endtask

    // code: expected fail code; fa: failing address; stop: last address of programming pass
    task automatic check_job(input int f, input int l, input int code, input int fa);
        int stop, fv_n, k, exp_p;
        logic [7:0] exp_m;
        stop = (code == 1 || code == 2) ? fa : l;
        fv_n = (code == 0) ? (l - f + 1) : (code == 3 ? fa - f + 1 : 0);
        check(done && !busy, "R10 done at end", {done, busy}, 2'b10);
        check(fail == (code != 0), "R10 fail flag", fail, code != 0);
        check(fail_code == 2'(code), "R6/R7/R9 fail code", fail_code, code);
        if (code != 0) check(fail_addr == 16'(fa), "R6/R7/R9 fail address", fail_addr, fa);
        check(!vpp_en && !vcc_hi && rom_ce_n && rom_oe_n && !rom_dout_en && !ord_bad,
              "R2 power released, vpp only with supply", {vpp_en, vcc_hi, ord_bad}, 0);
        check(hs_q.size() == (stop - f + 1) + fv_n, "R8 request count", hs_q.size(), (stop - f + 1) + fv_n);
        k = 0;
        for (int a = f; a <= stop; a++) begin
            if (k < hs_q.size()) check(hs_q[k] == 16'(a), "R8 request order pass 1", hs_q[k], a);
            k++;
        end
        for (int a = f; a < f + fv_n; a++) begin
            if (k < hs_q.size()) check(hs_q[k] == 16'(a), "R9 request order final pass", hs_q[k], a);
            k++;
        end
        check(fv_reads == fv_n * RCYC && !fv_bad, "R9 final reads at nominal supply", fv_reads, fv_n * RCYC);
        for (int a = f; a <= l; a++) begin
            if (a > stop || (img[a] & ~mem0[a]) != 0 || img[a] == mem0[a]) exp_p = 0;
            else exp_p = (need[a] > MAXP) ? MAXP : need[a];
            if (a == stop && code == 7) exp_p = 0;
            check(pcnt[a] == exp_p, "R5/R6/R7 pulses at address", pcnt[a], exp_p);
            exp_m = (exp_p > 0 && exp_p >= need[a]) ? (mem0[a] & img[a]) : mem0[a];
            if (!(decay_on && a == decay_a))
                check(mem[a] == exp_m, "R5 array contents", mem[a], exp_m);
        end
        for (int a = 16'h80; a <= 16'h81; a++)
            check(pcnt[a] == 0, "R11 start while busy ignored", pcnt[a], 0);
    endtask

    initial begin
        blank();
        repeat (3) @(negedge clk);
        check(!busy && !done && !fail && rom_ce_n && rom_oe_n && !rom_dout_en && !vpp_en
              && !vcc_hi && !req_valid, "R1 outputs during reset", {busy, done, vpp_en, vcc_hi}, 0);
        rst = 0;
        repeat (4) @(negedge clk);
        check(!busy && !done && !fail && rom_ce_n && rom_oe_n && !vpp_en && !vcc_hi && !req_valid,
              "R1 idle after reset", {busy, done, vpp_en, vcc_hi}, 0);

        // mixed pulse counts, already-matching bytes, pulse count equal to the limit
        blank();
        img[16'h10] = 8'hA5; need[16'h10] = 1;
        img[16'h11] = 8'h00; need[16'h11] = 3;
        mem[16'h14] = 8'hF0; img[16'h14] = 8'hF0;
        mem[16'h15] = 8'hF7; img[16'h15] = 8'h07; need[16'h15] = MAXP;
        img[16'h13] = 8'h3C; need[16'h13] = 2;
        img[16'h16] = 8'h81;
        img[16'h17] = 8'h7E; need[16'h17] = 2;
        run_job(16'h10, 16'h17, 1);
        check_job(16'h10, 16'h17, 0, 0);
        repeat (5) @(negedge clk);
        check(done && !busy && !fail, "R10 done holds", {done, busy}, 2'b10);

        // pulse limit
        blank();
        img[16'h20] = 8'h55; img[16'h21] = 8'h55; img[16'h22] = 8'h55; img[16'h23] = 8'h55;
        need[16'h22] = MAXP + 2;
        run_job(16'h20, 16'h23, 0);
        check_job(16'h20, 16'h23, 2, 16'h22);

        // unprogrammable byte
        blank();
        img[16'h30] = 8'h11;
        mem[16'h31] = 8'h0F; img[16'h31] = 8'hF0;
        img[16'h32] = 8'h22;
        run_job(16'h30, 16'h32, 0);
        check_job(16'h30, 16'h32, 1, 16'h31);

        // cell that leaks back once program voltage is removed
        blank();
        img[16'h40] = 8'h12; img[16'h41] = 8'h34; img[16'h42] = 8'h56; img[16'h43] = 8'h78;
        decay_on = 1; decay_a = 8'h42;
        run_job(16'h40, 16'h43, 0);
        check_job(16'h40, 16'h43, 3, 16'h42);
        decay_on = 0;

        // single-address range
        blank();
        img[16'h50] = 8'h00; need[16'h50] = 2;
        run_job(16'h50, 16'h50, 0);
        check_job(16'h50, 16'h50, 0, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule